// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the bus-facing register front end of an interrupt redirection controller. A simple single-cycle bus slave exposes two 32-bit locations: an 8-bit select register and a data window. The select value chooses what the window reaches. It can reach an identification register, a read-only version word, an arbitration word that mirrors the identification value, or one half of a 64-bit per-pin redirection entry.

The block holds the redirection table itself. It applies the field rules: two status bits in each entry can never be written from the bus, and the remote-pending bit is cleared whenever a write leaves an entry in edge-triggered mode. After every accepted entry write, a one-cycle strobe and the entry index tell the delivery logic which pin to re-evaluate. The delivery logic writes the two status bits back through a small dedicated port.

Entry layout:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode |
| 11 | destination mode |
| 12 | delivery status (read-only from the bus) |
| 13 | polarity |
| 14 | remote-pending (read-only from the bus) |
| 15 | trigger mode (1 = level, 0 = edge) |
| 16 | mask |
| 63:56 | destination |

Top module: `irq_window_regs`

## Requirements
- R1: A write to bus offset 0x00 loads bits 7:0 of the write data into the select register. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read (offset 0x10) returns NUM_PINS-1 in bits 23:16 and VERSION_CODE in bits 7:0, with all other bits zero. Window writes with select 0x01 change nothing.
- R3: With select 0x00, a window write stores write-data bits 27:24 as the 4-bit ID. Window reads with select 0x00 or 0x02 return the ID in bits 27:24 and zero elsewhere. Window writes with select 0x02 change nothing.
- R4: For select values 0x10 and above, the entry index is (select-0x10)>>1. An even select reaches entry bits 31:0 and an odd select reaches entry bits 63:32. A window write replaces that half and a window read returns it.
- R5: A window read returns 0xFFFFFFFF when the select is 0x03 to 0x0F or names an index at or beyond NUM_PINS. A window write with such a select changes no state and gives no strobe.
- R6: A bus write to either half of an entry leaves bits 12 and 14 of that entry at their previous values, whatever the data.
- R7: If a bus write leaves bit 15 of an entry at 0 (edge mode), bit 14 of that entry becomes 0.
- R8: After reset, every entry reads 0x0000_0000_0001_0000 (only the mask bit set). The select register is 0, the ID is 0, the read data is 0 and the strobe is low.
- R9: A read of any bus offset other than 0x00 and 0x10 returns 0. A write to such an offset changes nothing.
- R10: Read data is registered. It shows the addressed value in the cycle after the read request and holds until the next read request.
- R11: Each accepted entry write raises entry_wr_stb for exactly one cycle, in the cycle after the request, with entry_wr_idx giving the entry index.
- R12: When stat_valid is high and stat_idx is below NUM_PINS, bits 14 and 12 of that entry take stat_remote and stat_dlv at the next edge. This wins over a same-cycle bus write to that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register region |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| entry_wr_stb | output | 1 | One-cycle pulse after an accepted entry write |
| entry_wr_idx | output | IDX_W | Index of the entry just written |
| stat_valid | input | 1 | Status update from delivery logic |
| stat_idx | input | IDX_W | Entry whose status bits are updated |
| stat_remote | input | 1 | New remote-pending bit value |
| stat_dlv | input | 1 | New delivery-status bit value |

## Verification
The bench builds the block with its defaults: 24 pins, an 8-bit offset and version code 0x11. With these values the full 8-bit select space can be swept. That covers every in-range entry half, the boundary between index 23 and the first missing index at select 0x40, the gap at selects 0x03 to 0x0F, and the top value 0xFF. Entry data patterns vary with the index, so both trigger modes and both status-bit values in the written data occur across the table. The status port is used to set remote-pending and delivery-status bits. This makes it possible to see both bits preserved through bus writes, remote-pending cleared by edge mode, and a same-cycle collision between the two write paths.

// File: rtl/irq_window_regs.sv
module irq_window_regs #(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W = 8,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              entry_wr_stb,
  output logic [IDX_W-1:0]  entry_wr_idx,
  input  logic              stat_valid,
  input  logic [IDX_W-1:0]  stat_idx,
  input  logic              stat_remote,
  input  logic              stat_dlv
);

  localparam logic [ADDR_W-1:0] SEL_OFF = '0;
  localparam logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16);
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
  localparam int B_DLV = 12;
  localparam int B_REM = 14;
  localparam int B_TRG = 15;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] tbl [NUM_PINS];

  logic [6:0]       ent_off;
  logic             ent_ok;
  logic [IDX_W-1:0] ent_idx;
  logic             is_sel, is_win, bus_wr, bus_rd, ent_wr, stat_hit;
  logic [63:0]      ent_old, ent_new;
  logic [31:0]      rd_val;

  assign is_sel  = req_addr == SEL_OFF;
  assign is_win  = req_addr == WIN_OFF;
  assign bus_wr  = req_valid && req_write;
  assign bus_rd  = req_valid && !req_write;

  assign ent_off = sel_q[7:1] - 7'd8;
  assign ent_ok  = (sel_q >= 8'h10) && (int'(ent_off) < NUM_PINS);
  assign ent_idx = ent_ok ? ent_off[IDX_W-1:0] : '0;
  assign ent_wr  = bus_wr && is_win && ent_ok;
  assign stat_hit = stat_valid && (int'(stat_idx) < NUM_PINS);

  assign ent_old = tbl[ent_idx];

  always_comb begin
    ent_new = sel_q[0] ? {req_wdata, ent_old[31:0]} : {ent_old[63:32], req_wdata};
    ent_new[B_DLV] = ent_old[B_DLV];
    ent_new[B_REM] = ent_new[B_TRG] ? ent_old[B_REM] : 1'b0;
  end

  always_comb begin
    rd_val = '0;
    if (is_sel) begin
      rd_val = {24'h0, sel_q};
    end else if (is_win) begin
      if (sel_q == 8'h00 || sel_q == 8'h02)
        rd_val = {4'h0, id_q, 24'h0};
      else if (sel_q == 8'h01)
        rd_val = {8'h0, 8'(NUM_PINS - 1), 8'h0, VERSION_CODE};
      else if (ent_ok)
        rd_val = sel_q[0] ? ent_old[63:32] : ent_old[31:0];
      else
        rd_val = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q        <= '0;
      id_q         <= '0;
      rsp_rdata    <= '0;
      entry_wr_stb <= 1'b0;
      entry_wr_idx <= '0;
    end else begin
      entry_wr_stb <= ent_wr;
      if (ent_wr)
        entry_wr_idx <= ent_idx;
      if (bus_rd)
        rsp_rdata <= rd_val;
      if (bus_wr && is_sel)
        sel_q <= req_wdata[7:0];
      if (bus_wr && is_win && sel_q == 8'h00)
        id_q <= req_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++)
        tbl[i] <= ENTRY_RST;
    end else begin
      if (ent_wr)
        tbl[ent_idx] <= ent_new;
      if (stat_hit) begin
        tbl[stat_idx][B_REM] <= stat_remote;
        tbl[stat_idx][B_DLV] <= stat_dlv;
      end
    end
  end

  logic collide;
  assign collide = ent_wr && stat_hit && (stat_idx == ent_idx);

  assert_strobe_follows_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr |=> entry_wr_stb && (entry_wr_idx == $past(ent_idx)));

  assert_no_stray_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_wr |=> !entry_wr_stb);

  assert_status_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_wr && !collide) |=> tbl[$past(ent_idx)][B_DLV] == $past(ent_old[B_DLV]));

  assert_edge_clears_remote_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_wr && !collide) |=> (tbl[$past(ent_idx)][B_TRG] || !tbl[$past(ent_idx)][B_REM]));

  assert_bad_select_reads_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_win && !ent_ok && sel_q > 8'h02) |=> rsp_rdata == 32'hFFFF_FFFF);

  assert_other_offset_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_sel && !is_win) |=> rsp_rdata == 32'h0);

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rsp_rdata));

  assert_status_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |=> tbl[$past(stat_idx)][B_REM] == $past(stat_remote));

endmodule

// File: tb/sim_irq_window_regs.sv
module sim_irq_window_regs;
  localparam int N = 24;
  localparam int IW = 5;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic entry_wr_stb;
  logic [IW-1:0] entry_wr_idx;
  logic stat_valid = 1'b0, stat_remote = 1'b0, stat_dlv = 1'b0;
  logic [IW-1:0] stat_idx = '0;

  always #4 clk = ~clk;

  irq_window_regs #(.NUM_PINS(N), .ADDR_W(8), .VERSION_CODE(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .entry_wr_stb(entry_wr_stb), .entry_wr_idx(entry_wr_idx),
    .stat_valid(stat_valid), .stat_idx(stat_idx), .stat_remote(stat_remote),
    .stat_dlv(stat_dlv));

  int vecs = 0, errs = 0;
  logic stb_seen;
  logic [IW-1:0] idx_seen;
  logic [63:0] m [N];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    stb_seen = entry_wr_stb; idx_seen = entry_wr_idx;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  function automatic void mwr(input int i, input bit hi, input logic [31:0] d);
    logic [63:0] o, n;
    o = m[i];
    n = hi ? {d, o[31:0]} : {o[63:32], d};
    n[12] = o[12];
    if (!n[15]) n[14] = 1'b0;
    else n[14] = o[14];
    m[i] = n;
  endfunction

  task automatic ewr(input int i, input bit hi, input logic [31:0] d);
    wr(8'h00, 32'(8'h10 + 2 * i + int'(hi)));
    wr(8'h10, d);
    mwr(i, hi, d);
    chk("R11 strobe", {63'h0, stb_seen}, 64'h1);
    chk("R11 index", {59'h0, idx_seen}, 64'(i));
  endtask

  task automatic erd(input string r, input int i, input bit hi);
    logic [31:0] d;
    wr(8'h00, 32'(8'h10 + 2 * i + int'(hi)));
    rd(8'h10, d);
    chk(r, {32'h0, d}, {32'h0, hi ? m[i][63:32] : m[i][31:0]});
  endtask

  task automatic st(input int i, input logic r, input logic dv);
    @(negedge clk);
    stat_valid = 1'b1; stat_idx = IW'(i); stat_remote = r; stat_dlv = dv;
    @(posedge clk);
    @(negedge clk);
    stat_valid = 1'b0;
    m[i][14] = r; m[i][12] = dv;
  endtask

  task automatic check_all(input string r);
    for (int i = 0; i < N; i++) begin
      erd(r, i, 1'b0);
      erd(r, i, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    for (int i = 0; i < N; i++) m[i] = 64'h0000_0000_0001_0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8 reset state
    chk("R8 rdata", {32'h0, rsp_rdata}, 64'h0);
    chk("R8 strobe", {63'h0, entry_wr_stb}, 64'h0);
    rd(8'h00, d); chk("R8 select", {32'h0, d}, 64'h0);
    rd(8'h10, d); chk("R8 id", {32'h0, d}, 64'h0);
    check_all("R8 entry reset");

    // R1 select register
    wr(8'h00, 32'hDEAD_BE5A); rd(8'h00, d);
    chk("R1 select low byte", {32'h0, d}, 64'h5A);

    // R2 version
    wr(8'h00, 32'h01); rd(8'h10, d);
    chk("R2 version", {32'h0, d}, {32'h0, 8'h0, 8'(N - 1), 8'h0, VER});
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d);
    chk("R2 version write ignored", {32'h0, d}, {32'h0, 8'h0, 8'(N - 1), 8'h0, VER});

    // R3 identification and arbitration
    wr(8'h00, 32'h00); wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d);
    chk("R3 id", {32'h0, d}, 64'h0F00_0000);
    wr(8'h00, 32'h02); rd(8'h10, d);
    chk("R3 arb mirrors id", {32'h0, d}, 64'h0F00_0000);
    wr(8'h10, 32'h0000_0000); rd(8'h10, d);
    chk("R3 arb write ignored", {32'h0, d}, 64'h0F00_0000);
    wr(8'h00, 32'h00); wr(8'h10, 32'h0500_0000); rd(8'h10, d);
    chk("R3 id rewrite", {32'h0, d}, 64'h0500_0000);

    // R4 full table sweep with varied patterns; R6/R7 on data bits
    for (int i = 0; i < N; i++) begin
      logic [31:0] lo, hi;
      lo = 32'h0003_0000 ^ (32'(i) * 32'h0000_0111) ^ (i[0] ? 32'h0000_8000 : 32'h0)
           ^ (i[1] ? 32'h0000_5000 : 32'h0);
      hi = {8'(i * 11 + 3), 24'(i * 32'h0001_0203)};
      ewr(i, 1'b0, lo);
      ewr(i, 1'b1, hi);
    end
    check_all("R4 entry readback");

    // R5 out-of-range reads
    for (int s = 3; s < 16; s++) begin
      wr(8'h00, 32'(s)); rd(8'h10, d);
      chk("R5 gap select reads ones", {32'h0, d}, 64'hFFFF_FFFF);
    end
    for (int s = 16 + 2 * N; s < 256; s++) begin
      wr(8'h00, 32'(s)); rd(8'h10, d);
      chk("R5 beyond table reads ones", {32'h0, d}, 64'hFFFF_FFFF);
    end
    // R5 dropped writes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s;
      s = (k == 0) ? 8'h03 : (k == 1) ? 8'h0F : (k == 2) ? 8'(16 + 2 * N) : 8'hFF;
      wr(8'h00, {24'h0, s}); wr(8'h10, 32'hFFFF_FFFF);
      chk("R5 no strobe on dropped write", {63'h0, stb_seen}, 64'h0);
    end
    check_all("R5 table untouched");

    // R9 other offsets
    for (int a = 1; a < 256; a = a * 2 + 3) begin
      if (a != 16) begin
        rd(8'(a), d);
        chk("R9 other offset reads zero", {32'h0, d}, 64'h0);
      end
    end
    wr(8'h00, 32'h12); wr(8'h04, 32'h0000_0077); wr(8'hF0, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R9 write elsewhere ignored", {32'h0, d}, 64'h12);
    chk("R9 no strobe", {63'h0, stb_seen}, 64'h0);

    // R10 hold
    wr(8'h00, 32'h01); rd(8'h10, prev);
    wr(8'h00, 32'h33);
    @(negedge clk);
    chk("R10 rdata holds across writes", {32'h0, rsp_rdata}, {32'h0, prev});

    // R12, R6: status set, then writes keep it on a level entry
    ewr(5, 1'b0, 32'h0001_8020);
    st(5, 1'b1, 1'b1);
    erd("R12 status loaded", 5, 1'b0);
    ewr(5, 1'b0, 32'h0000_8021);
    erd("R6 status kept on low write", 5, 1'b0);
    ewr(5, 1'b1, 32'hAB00_0000);
    erd("R6 status kept on high write", 5, 1'b0);
    chk("R6 bits 12/14 still set", {62'h0, m[5][14], m[5][12]}, 64'h3);
    // R6: data bits 12/14 cannot set status
    st(6, 1'b0, 1'b0);
    ewr(6, 1'b0, 32'h0000_D030);
    erd("R6 data cannot set status", 6, 1'b0);
    // R7: switching to edge clears remote, keeps delivery status
    ewr(5, 1'b0, 32'h0000_0021);
    erd("R7 edge clears remote", 5, 1'b0);
    chk("R7 model remote zero", {63'h0, m[5][14]}, 64'h0);
    // R7: high write on an edge entry whose remote was set by status
    st(7, 1'b1, 1'b0);
    if (m[7][15]) ewr(7, 1'b0, 32'h0000_0042);
    st(7, 1'b1, 1'b0);
    ewr(7, 1'b1, 32'h1100_0000);
    erd("R7 high write on edge entry clears remote", 7, 1'b0);

    // R12 collision: status port wins
    ewr(9, 1'b0, 32'h0000_8055);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 32'h0000_0056;
    stat_valid = 1'b1; stat_idx = IW'(9); stat_remote = 1'b1; stat_dlv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; stat_valid = 1'b0;
    chk("R11 strobe on collision", {63'h0, entry_wr_stb}, 64'h1);
    mwr(9, 1'b0, 32'h0000_0056);
    m[9][14] = 1'b1; m[9][12] = 1'b1;
    erd("R12 status wins collision", 9, 1'b0);

    check_all("R4 final table");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule